// File: doc/BRIEF.md
# Multi-Format Serial Audio Transmitter

This block is the clock master of a two-channel serial audio output link. From the system clock it derives three outputs through programmable dividers: a master clock for the converter, a bit clock and a word-select (or frame-sync) line. Left/right sample pairs arrive on a valid/ready stream. Each pair is serialized most significant bit first on one data line. The data line and word-select change on the falling edge of the bit clock, so a receiver samples them on the rising edge.

The framing is chosen at run time. Five formats are available: the one-bit-delayed standard format, left-justified, right-justified, PCM with a one-bit frame-sync pulse, and PCM with a frame-sync pulse of programmable width. The slot width and the data width are set separately. A data width below the slot width is padded with zeros. The block sends a single left sample in mono mode and two samples in stereo mode. A one-frame holding register decouples the stream from the frame timing. When no pair is ready at a frame boundary, the block sends a silent frame and raises a sticky underrun flag.

Back-pressure rules: `s_ready` is high exactly when the holding register is empty. A pair is taken on any clock edge where `s_valid` and `s_ready` are both high. Once taken, `s_ready` stays low until the frame engine moves the pair into the transmit registers at the next frame boundary. A pair that is offered in the same cycle as a boundary with an empty holding register goes straight into the transmit registers, and `s_ready` stays high.

Top module: `aud_ser_tx`

## Requirements
- R1: The master clock toggles once every `mclk_div`+1 system clocks. Every frame lasts exactly M master-clock periods, where M is 128 for `mclk_sel`=0, 256 for `mclk_sel`=1, and 512 for `mclk_sel`=2 or 3. A frame is 2×`slot_bits` bit-clock periods.
- R2: Samples leave MSB first. `sd_o` and `ws_o` change only in the cycle where `bclk_o` falls, so they are stable at each rising edge.
- R3: With `fmt`=0 (delayed standard), frame position 0 is the first bit period with word-select low. Word-select is low for the left slot and high for the right slot. The MSB of each channel follows its word-select change by one bit period.
- R4: With `fmt`=1 (left-justified), the word-select levels are the same as for `fmt`=0, and the MSB is sent in the same bit period as the word-select change. Codes 5 to 7 behave as `fmt`=1.
- R5: With `fmt`=2 (right-justified), the LSB fills the last bit period of each slot. Bits ahead of the sample in the slot are zero.
- R6: With `fmt`=3 (PCM short), word-select is active only in frame position 0. The left MSB follows at position 1, and the right slot starts right after the left slot.
- R7: With `fmt`=4 (PCM long), word-select is active for the first `fs_len` bit periods of the frame. The data is placed as in `fmt`=3.
- R8: Samples are right-aligned on `s_left`/`s_right`, and only the low `data_bits` bits are sent. When `data_bits` < `slot_bits`, the remaining bit periods of the slot are zero: after the sample, or ahead of it for `fmt`=2.
- R9: `ws_inv`=1 inverts the word-select output in every format.
- R10: With `mono`=1, `s_left` goes in the left slot and the right slot carries zeros whatever `s_right` holds.
- R11: One-frame holding register with the back-pressure rules above. After reset `s_ready` is 1. After a pair is taken while the link is idle, `s_ready` is 0 until the next frame boundary.
- R12: At a frame boundary with no pair held or offered, the frame is sent as all zeros and `underrun_o` is set. The flag stays high until a one-cycle `urun_clr` pulse clears it. A new underrun in the same cycle wins over the clear.
- R13: While `en` is 0, `bclk_o`, `mclk_o` and `sd_o` are low and the frame position is reset. After `en` rises, the first falling edge of `bclk_o` starts frame position 0. After reset, `underrun_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on `clk` |
| en | input | 1 | Runs the clocks and frame engine when high |
| fmt | input | 3 | Framing format code (0 standard, 1 left, 2 right, 3 PCM short, 4 PCM long) |
| slot_bits | input | 6 | Bit periods per channel slot |
| data_bits | input | 6 | Sample bits sent per slot |
| fs_len | input | 7 | Frame-sync width in bit periods for `fmt`=4 |
| mono | input | 1 | Send only the left sample |
| ws_inv | input | 1 | Invert word-select |
| mclk_sel | input | 2 | Master clock multiple of the sample rate |
| mclk_div | input | 8 | System clocks per master-clock half period, minus one |
| urun_clr | input | 1 | Clears the underrun flag |
| s_valid | input | 1 | Sample pair offered |
| s_ready | output | 1 | Holding register empty |
| s_left | input | 32 | Left sample, right-aligned |
| s_right | input | 32 | Right sample, right-aligned |
| mclk_o | output | 1 | Master clock |
| bclk_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word-select or frame-sync |
| sd_o | output | 1 | Serial data |
| underrun_o | output | 1 | Sticky underrun flag |

## Verification
The assertions assume that the configuration inputs (`fmt`, widths, `mono`, `ws_inv`, the clock selections) are held steady while `en` is high. They also assume `data_bits` ≤ `slot_bits` and, for `fmt`=4, 1 ≤ `fs_len` ≤ 2×`slot_bits`. Under these conditions the stability and mono checks follow from the frame position alone. The stimulus changes configuration only with `en` low, between runs. Every sample it draws is a full random 32-bit word, so unused high bits and the ignored right word in mono mode are exercised while the settings stay legal.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;
  typedef enum logic [2:0] {
    FMT_STD  = 3'd0,
    FMT_LJ   = 3'd1,
    FMT_RJ   = 3'd2,
    FMT_PCMS = 3'd3,
    FMT_PCML = 3'd4
  } fmt_e;
endpackage

// File: rtl/aud_clk_gen.sv
module aud_clk_gen #(
  parameter int DIVW = 8,
  parameter int SBW  = 6,
  parameter int AW   = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [1:0]      mclk_sel,
  input  logic [DIVW-1:0] mclk_div,
  input  logic [SBW-1:0]  slot_bits,
  output logic            mclk_o,
  output logic            bclk_o,
  output logic            fall_tick
);
  logic [DIVW-1:0] mcnt;
  logic [AW-1:0]   acc, lim, step, sum;
  logic            tick, hit, mclk_q, bclk_q;

  // Fractional rate: each master-clock half period adds 2F bit edges worth,
  // a bit-clock edge fires whenever 2M is crossed, so one frame = M mclk periods.
  always_comb begin
    case (mclk_sel)
      2'd0:    lim = AW'(256);
      2'd1:    lim = AW'(512);
      default: lim = AW'(1024);
    endcase
    step      = AW'({slot_bits, 2'b00});
    sum       = acc + step;
    tick      = (mcnt == mclk_div);
    hit       = (sum >= lim);
    fall_tick = en && tick && hit && bclk_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      mcnt   <= '0;
      acc    <= '0;
      mclk_q <= 1'b0;
      bclk_q <= 1'b0;
    end else if (tick) begin
      mcnt   <= '0;
      mclk_q <= ~mclk_q;
      if (hit) begin
        acc    <= sum - lim;
        bclk_q <= ~bclk_q;
      end else begin
        acc <= sum;
      end
    end else begin
      mcnt <= mcnt + 1'b1;
    end
  end

  assign mclk_o = mclk_q;
  assign bclk_o = bclk_q;
endmodule

// File: rtl/aud_slot_map.sv
module aud_slot_map
  import aud_tx_pkg::*;
#(
  parameter int MAXW = 32,
  parameter int SBW  = 6,
  parameter int PW   = 6
) (
  input  logic [2:0]      fmt,
  input  logic [PW-1:0]   p,
  input  logic [SBW-1:0]  slot_bits,
  input  logic [SBW-1:0]  data_bits,
  input  logic [PW:0]     fs_len,
  input  logic            mono,
  input  logic            ws_inv,
  input  logic [MAXW-1:0] cur_l,
  input  logic [MAXW-1:0] cur_r,
  output logic            ws,
  output logic            sd,
  output logic            off
);
  localparam int LW = PW + 1;
  localparam int IW = $clog2(MAXW);

  fmt_e            f;
  logic            dly, right, have, lvl;
  logic [LW-1:0]   pe, flen, slot_e, db, q, i;
  logic [IW-1:0]   idx;
  logic [MAXW-1:0] word;

  always_comb begin
    f      = fmt_e'(fmt);
    dly    = (f == FMT_STD) || (f == FMT_PCMS) || (f == FMT_PCML);
    pe     = {1'b0, p};
    flen   = LW'({slot_bits, 1'b0});
    slot_e = LW'(slot_bits);
    db     = LW'(data_bits);
    // position inside the frame that owns the current bit
    q      = (dly && (p == '0)) ? flen - LW'(1) : pe - LW'(dly);
    right  = (q >= slot_e);
    i      = right ? q - slot_e : q;
    word   = right ? (mono ? '0 : cur_r) : cur_l;
    if (f == FMT_RJ) begin
      have = (i >= slot_e - db);
      idx  = IW'(slot_e - LW'(1) - i);
    end else begin
      have = (i < db);
      idx  = IW'(db - LW'(1) - i);
    end
    sd = have ? word[idx] : 1'b0;
    case (f)
      FMT_PCMS: lvl = (p == '0);
      FMT_PCML: lvl = (pe < fs_len);
      default:  lvl = (pe >= slot_e);
    endcase
    ws  = lvl ^ ws_inv;
    off = dly;
  end
endmodule

// File: rtl/aud_hold.sv
module aud_hold #(
  parameter int MAXW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            load,
  input  logic            urun_clr,
  input  logic            s_valid,
  output logic            s_ready,
  input  logic [MAXW-1:0] s_left,
  input  logic [MAXW-1:0] s_right,
  output logic [MAXW-1:0] cur_l,
  output logic [MAXW-1:0] cur_r,
  output logic            underrun
);
  logic [MAXW-1:0] hold_l, hold_r;
  logic            hv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hv       <= 1'b0;
      hold_l   <= '0;
      hold_r   <= '0;
      cur_l    <= '0;
      cur_r    <= '0;
      underrun <= 1'b0;
    end else begin
      if (load) begin
        if (hv) begin
          cur_l <= hold_l;
          cur_r <= hold_r;
          hv    <= 1'b0;
        end else if (s_valid) begin
          cur_l <= s_left;
          cur_r <= s_right;
        end else begin
          cur_l <= '0;
          cur_r <= '0;
        end
      end else if (!en) begin
        cur_l <= '0;
        cur_r <= '0;
      end
      if (s_valid && !hv && !load) begin
        hold_l <= s_left;
        hold_r <= s_right;
        hv     <= 1'b1;
      end
      if (load && !hv && !s_valid) underrun <= 1'b1;
      else if (urun_clr)           underrun <= 1'b0;
    end
  end

  assign s_ready = !hv;
endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx #(
  parameter int MAXW = 32,
  parameter int DIVW = 8,
  localparam int SBW = $clog2(MAXW + 1),
  localparam int PW  = $clog2(2 * MAXW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [2:0]      fmt,
  input  logic [SBW-1:0]  slot_bits,
  input  logic [SBW-1:0]  data_bits,
  input  logic [PW:0]     fs_len,
  input  logic            mono,
  input  logic            ws_inv,
  input  logic [1:0]      mclk_sel,
  input  logic [DIVW-1:0] mclk_div,
  input  logic            urun_clr,
  input  logic            s_valid,
  output logic            s_ready,
  input  logic [MAXW-1:0] s_left,
  input  logic [MAXW-1:0] s_right,
  output logic            mclk_o,
  output logic            bclk_o,
  output logic            ws_o,
  output logic            sd_o,
  output logic            underrun_o
);
  localparam int AW = $clog2(1024 + 4 * MAXW + 1);

  logic            fall_tick, off, load;
  logic [PW-1:0]   p, nxt, flast;
  logic [SBW:0]    fbits;
  logic [MAXW-1:0] cur_l, cur_r;

  aud_clk_gen #(.DIVW(DIVW), .SBW(SBW), .AW(AW)) u_clk (
    .clk(clk), .rst_n(rst_n), .en(en), .mclk_sel(mclk_sel),
    .mclk_div(mclk_div), .slot_bits(slot_bits),
    .mclk_o(mclk_o), .bclk_o(bclk_o), .fall_tick(fall_tick)
  );

  always_comb begin
    fbits = {slot_bits, 1'b0};
    flast = PW'(fbits - 1'b1);
    nxt   = (p == flast) ? '0 : p + 1'b1;
    load  = fall_tick && (nxt == PW'(off));
  end

  // frame position of the bit currently on the line
  always_ff @(posedge clk) begin
    if (!rst_n)         p <= '0;
    else if (!en)       p <= flast;
    else if (fall_tick) p <= nxt;
  end

  aud_hold #(.MAXW(MAXW)) u_hold (
    .clk(clk), .rst_n(rst_n), .en(en), .load(load), .urun_clr(urun_clr),
    .s_valid(s_valid), .s_ready(s_ready), .s_left(s_left), .s_right(s_right),
    .cur_l(cur_l), .cur_r(cur_r), .underrun(underrun_o)
  );

  aud_slot_map #(.MAXW(MAXW), .SBW(SBW), .PW(PW)) u_map (
    .fmt(fmt), .p(p), .slot_bits(slot_bits), .data_bits(data_bits),
    .fs_len(fs_len), .mono(mono), .ws_inv(ws_inv),
    .cur_l(cur_l), .cur_r(cur_r), .ws(ws_o), .sd(sd_o), .off(off)
  );
endmodule

// File: rtl/aud_ser_tx_chk.sv
module aud_ser_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic [2:0] fmt,
  input logic       mono,
  input logic       ws_inv,
  input logic       urun_clr,
  input logic       s_valid,
  input logic       s_ready,
  input logic       mclk_o,
  input logic       bclk_o,
  input logic       ws_o,
  input logic       sd_o,
  input logic       underrun_o,
  input logic       load
);
  AST_LINE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !$fell(bclk_o)) |-> ($stable(sd_o) && $stable(ws_o))); // R2

  AST_MONO_RIGHT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mono && fmt == 3'd1 && ws_o != ws_inv) |-> !sd_o); // R10

  AST_HOLD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && !load) |=> !s_ready); // R11

  AST_URUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun_o && !urun_clr) |=> underrun_o); // R12

  AST_URUN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (urun_clr && !load) |=> !underrun_o); // R12

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!bclk_o && !mclk_o)); // R13
endmodule

bind aud_ser_tx aud_ser_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .fmt(fmt), .mono(mono), .ws_inv(ws_inv),
  .urun_clr(urun_clr), .s_valid(s_valid), .s_ready(s_ready),
  .mclk_o(mclk_o), .bclk_o(bclk_o), .ws_o(ws_o), .sd_o(sd_o),
  .underrun_o(underrun_o), .load(load)
);

// File: tb/aud_ser_tx_bench.sv
`timescale 1ns/1ps
module aud_ser_tx_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [2:0]  fmt = '0;
  logic [5:0]  slot_bits = 6'd16;
  logic [5:0]  data_bits = 6'd16;
  logic [6:0]  fs_len = 7'd1;
  logic        mono = 1'b0;
  logic        ws_inv = 1'b0;
  logic [1:0]  mclk_sel = '0;
  logic [7:0]  mclk_div = '0;
  logic        urun_clr = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [31:0] s_left = '0;
  logic [31:0] s_right = '0;
  logic        mclk_o, bclk_o, ws_o, sd_o, underrun_o;

  always #4 clk = ~clk;

  aud_ser_tx u_aud_ser_tx (
    .clk(clk), .rst_n(rst_n), .en(en), .fmt(fmt), .slot_bits(slot_bits),
    .data_bits(data_bits), .fs_len(fs_len), .mono(mono), .ws_inv(ws_inv),
    .mclk_sel(mclk_sel), .mclk_div(mclk_div), .urun_clr(urun_clr),
    .s_valid(s_valid), .s_ready(s_ready), .s_left(s_left), .s_right(s_right),
    .mclk_o(mclk_o), .bclk_o(bclk_o), .ws_o(ws_o), .sd_o(sd_o),
    .underrun_o(underrun_o)
  );

  int    nvec = 0, nfail = 0;
  bit    done = 1'b0;
  bit    exp_q[$];
  bit    mon_on = 1'b0;
  int    consumed = 0;
  string tag = "R13";
  // model configuration
  int    m_fmt, m_slot, m_db, m_fsl, m_mult;
  bit    m_mono, m_inv;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic bit exp_bit(input logic [31:0] l, input logic [31:0] r, input int q);
    int i;
    logic [31:0] w;
    w = (q >= m_slot) ? (m_mono ? 32'd0 : r) : l;
    i = q % m_slot;
    if (m_fmt == 2) return (i >= m_slot - m_db) ? w[m_slot - 1 - i] : 1'b0;
    return (i < m_db) ? w[m_db - 1 - i] : 1'b0;
  endfunction

  function automatic bit exp_ws(input int p);
    bit lvl;
    if (m_fmt == 3)      lvl = (p == 0);
    else if (m_fmt == 4) lvl = (p < m_fsl);
    else                 lvl = (p >= m_slot);
    return lvl ^ m_inv;
  endfunction

  // monitor: samples every bit-clock rising edge and scores it
  initial begin
    int rises, mcl, frames;
    bit pb, pm, eb;
    rises = 0; mcl = 0; frames = 0; pb = 0; pm = 0;
    forever begin
      @(posedge clk); #1;
      if (mon_on) begin
        if (mclk_o && !pm) mcl++;
        if (bclk_o && !pb) begin
          if (rises > 0) begin
            int g, p, fl, off;
            g   = rises - 1;
            fl  = 2 * m_slot;
            p   = g % fl;
            off = (m_fmt == 0 || m_fmt == 3 || m_fmt == 4) ? 1 : 0;
            if (p == 0) begin
              if (frames > 0) chk("R1 mclk per frame", mcl, m_mult);
              mcl = 0;
              frames++;
            end
            chk({"R2 ws ", tag}, ws_o, exp_ws(p));
            if (off == 1 && g == 0) eb = 1'b0;
            else if (exp_q.size() == 0) begin
              eb = 1'bx;
            end else begin
              eb = exp_q.pop_front();
              consumed++;
            end
            chk({"R2 data ", tag}, sd_o, eb);
          end
          rises++;
        end
        pb = bclk_o; pm = mclk_o;
      end else begin
        rises = 0; mcl = 0; frames = 0; pb = 0; pm = 0;
      end
    end
  end

  task automatic push_pair(input logic [31:0] l, input logic [31:0] r);
    @(negedge clk);
    while (!s_ready) @(negedge clk);
    s_valid = 1'b1; s_left = l; s_right = r;
    for (int q = 0; q < 2 * m_slot; q++) exp_q.push_back(exp_bit(l, r, q));
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic run(input int f, input int sl, input int db, input bit mo, input bit inv,
                     input int msel, input int mdiv, input int fsl, input int nf,
                     input int skip, input string t);
    @(negedge clk);
    tag = t;
    m_fmt = f; m_slot = sl; m_db = db; m_mono = mo; m_inv = inv; m_fsl = fsl;
    m_mult = (msel == 0) ? 128 : (msel == 1) ? 256 : 512;
    fmt = 3'(f); slot_bits = 6'(sl); data_bits = 6'(db); mono = mo; ws_inv = inv;
    mclk_sel = 2'(msel); mclk_div = 8'(mdiv); fs_len = 7'(fsl);
    exp_q.delete(); consumed = 0;
    urun_clr = 1'b1; @(negedge clk); urun_clr = 1'b0;
    push_pair($urandom(), $urandom());
    chk("R11 ready low while holding", s_ready, 1'b0);
    en = 1'b1; mon_on = 1'b1;
    for (int k = 1; k < nf; k++) begin
      if (k == skip) begin
        @(negedge clk);
        while (!s_ready) @(negedge clk);
        chk("R12 flag clear before gap", underrun_o, 1'b0);
        for (int q = 0; q < 2 * m_slot; q++) exp_q.push_back(1'b0);
        while (!underrun_o) @(negedge clk);
        chk("R12 flag set on gap", underrun_o, 1'b1);
      end else begin
        push_pair($urandom(), $urandom());
        if (skip >= 0 && k == skip + 2) begin
          chk("R12 flag sticky", underrun_o, 1'b1);
          urun_clr = 1'b1; @(negedge clk); urun_clr = 1'b0;
          chk("R12 flag cleared", underrun_o, 1'b0);
        end
      end
    end
    while (consumed < nf * 2 * m_slot) @(negedge clk);
    mon_on = 1'b0; en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R13 clocks idle low", {30'd0, bclk_o, mclk_o}, 32'd0);
    chk("R13 data idle low", sd_o, 1'b0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13 reset bclk", bclk_o, 1'b0);
    chk("R13 reset mclk", mclk_o, 1'b0);
    chk("R13 reset sd", sd_o, 1'b0);
    chk("R12 reset flag", underrun_o, 1'b0);
    chk("R11 reset ready", s_ready, 1'b1);
    //  fmt slot db mono inv msel mdiv fsl frames skip tag
    run(0, 16, 16, 0, 0, 0, 0, 1, 5, -1, "R3");
    run(1, 32, 32, 0, 0, 0, 0, 1, 5, -1, "R4");
    run(2, 32, 24, 0, 0, 0, 0, 1, 5, -1, "R5");
    run(3, 16, 16, 0, 0, 0, 0, 1, 5, -1, "R6");
    run(4, 16, 16, 0, 0, 2, 0, 5, 4, -1, "R7");
    run(1, 32, 24, 0, 0, 1, 0, 1, 4, -1, "R8");
    run(0, 32, 20, 0, 1, 0, 1, 1, 4, -1, "R9");
    run(1, 16, 16, 1, 0, 0, 0, 1, 5, -1, "R10");
    run(1, 16, 16, 0, 0, 0, 0, 1, 7, 3, "R12");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule